// File: doc/BRIEF.md
# Programmable LCD Panel Timing Generator

This block derives the scan timing for an active-matrix panel from a free-running reference clock. A divider turns the reference clock into a pixel strobe, or passes every reference cycle through when bypassed. Two copies of one region state machine then walk each line and each frame through sync, back porch, active and front porch. The vertical copy steps once per finished line. All geometry arrives on static field inputs in offset form. The block drives horizontal sync, vertical sync, data enable and a panel clock level. Each of these outputs has its own polarity select.

Both copies of the machine use the same four states. SYNC goes to BACK, or straight to ACTIVE when the back porch length is zero. BACK goes to ACTIVE. ACTIVE goes to FRONT, or straight to SYNC when the front porch length is zero. FRONT goes to SYNC. The horizontal machine wraps when it leaves its last region, and that wrap is the step of the vertical machine. When the enable input is low, both machines are forced to SYNC with a zero count.

The current vertical region goes out as a 2-bit code, so a frame buffer or interrupt logic can follow the scan. A one-cycle strobe marks every region change, and a second strobe marks the start of each frame.

Top module: `lcd_timing_gen`

## Requirements
- R1: With `div_bypass` low, `pclk_en` is high for exactly one reference cycle in every `pcd`+2 cycles. The first pulse comes `pcd`+1 cycles after enable. With `div_bypass` high, `pclk_en` is high on every enabled cycle.
- R2: In divided mode with N = `pcd`+2, the raw panel clock level is high for the first floor(N/2) cycles of each pixel period and low for the rest. The timing outputs therefore change on its rising edge. `pclk_out` is that level XOR `inv_pclk`. In bypass, `pclk_out` holds the constant `inv_pclk`.
- R3: A line is, in pixel periods: sync `hsw`+1, then back porch `hbp`+1, then active 16×(`ppl`+1), then front porch `hfp`+1. Horizontal sync is asserted during the sync part.
- R4: A frame is, in lines: sync `vsw`+1, then back porch `vbp`, then active `lpp`+1, then front porch `vfp`. A porch of length zero is skipped. Vertical sync is asserted during the sync lines.
- R5: Data enable is asserted only when the horizontal and the vertical positions are both in their active regions.
- R6: `inv_hsync`, `inv_vsync` and `inv_de` each invert only their own output, so the active level becomes low.
- R7: `vregion` gives the vertical region: 00 sync, 01 back porch, 10 active, 11 front porch.
- R8: `vregion_chg` is high for one cycle in the first cycle of each new vertical region. This includes the first cycle after enable.
- R9: `frame_start` is high for one cycle in the first cycle of each frame's sync region. This includes the first cycle after enable.
- R10: While `en` is low, the following hold: sync and data enable sit at their inactive levels, `pclk_en` and both strobes are 0, `vregion` is 00 and `pclk_out` equals `inv_pclk`. After `en` rises again, the scan restarts at the first pixel of a frame.
- R11: The largest field values work: a 1024-pixel active line with 256-clock horizontal sync and porches, and 255-line vertical porches.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| en | input | 1 | Timing enable; low holds the block idle |
| ppl | input | 6 | Active pixels per line, as value/16 − 1 |
| hsw | input | 8 | Horizontal sync width − 1 |
| hbp | input | 8 | Horizontal back porch − 1 |
| hfp | input | 8 | Horizontal front porch − 1 |
| vsw | input | 6 | Vertical sync lines − 1 |
| vbp | input | 8 | Vertical back porch lines |
| vfp | input | 8 | Vertical front porch lines |
| lpp | input | 10 | Active lines − 1 |
| pcd | input | 10 | Divider setting; period is value + 2 |
| div_bypass | input | 1 | Pixel strobe on every reference cycle |
| inv_hsync | input | 1 | Horizontal sync active low |
| inv_vsync | input | 1 | Vertical sync active low |
| inv_de | input | 1 | Data enable active low |
| inv_pclk | input | 1 | Data changes on falling panel clock edge |
| pclk_en | output | 1 | Pixel strobe, one reference cycle wide |
| pclk_out | output | 1 | Panel clock level |
| hsync | output | 1 | Horizontal sync |
| vsync | output | 1 | Vertical sync |
| de | output | 1 | Data enable |
| vregion | output | 2 | Current vertical region code |
| vregion_chg | output | 1 | Strobe on vertical region change |
| frame_start | output | 1 | Strobe at the start of each frame |

## Verification
A wrong divider count shows up in `pclk_en` and `pclk_out` within one pixel period. From there it spreads to every later sync edge. A wrong horizontal state or count moves the `hsync` and `de` edges within the same line. A wrong vertical state or count shows on `vsync`, `vregion` and the strobes at the next line boundary. For that reason each configuration is compared cycle by cycle over a full frame plus one line. The comparison is against a position-based formula, so a single misplaced edge is caught where it happens.

// File: rtl/lcdt_pkg.sv
package lcdt_pkg;

    // Scan region of one axis; the code is exported on vregion.
    typedef enum logic [1:0] {
        RG_SYNC   = 2'b00,
        RG_BACK   = 2'b01,
        RG_ACTIVE = 2'b10,
        RG_FRONT  = 2'b11
    } region_e;

endpackage

// File: rtl/lcdt_clkdiv.sv
module lcdt_clkdiv #(
    parameter int PCD_W = 10
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             en,
    input  logic             bypass,
    input  logic [PCD_W-1:0] pcd,
    output logic             pclk_en,
    output logic             pclk_lvl
);
    localparam int CW = PCD_W + 1;

    logic [CW-1:0] dcnt;
    logic [CW-1:0] period_m1;
    logic [CW-1:0] period;
    logic [CW-1:0] half;
    logic          at_end;

    assign period_m1 = {1'b0, pcd} + CW'(1);
    assign period    = {1'b0, pcd} + CW'(2);
    assign half      = period >> 1;
    assign at_end    = (dcnt >= period_m1);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            dcnt <= '0;
        end else if (!en || bypass || at_end) begin
            dcnt <= '0;
        end else begin
            dcnt <= dcnt + CW'(1);
        end
    end

    assign pclk_en  = en & (bypass | at_end);
    assign pclk_lvl = en & ~bypass & (dcnt < half);

    // R1: in divided mode two pixel strobes never come back to back
    a_r1_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        (en && !bypass && pclk_en) |=> (!pclk_en || bypass || !en));

    // R2: the panel clock level is high right after a pixel boundary
    a_r2_high_after_strobe: assert property (@(posedge clk) disable iff (!rst_n)
        (en && !bypass && pclk_en) |=> (pclk_lvl || bypass || !en));

endmodule

// File: rtl/lcdt_axis.sv
module lcdt_axis
    import lcdt_pkg::*;
#(
    parameter int LEN_W = 11
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             en,
    input  logic             step,
    input  logic [LEN_W-1:0] len_sync,
    input  logic [LEN_W-1:0] len_back,
    input  logic [LEN_W-1:0] len_active,
    input  logic [LEN_W-1:0] len_front,
    output region_e          region_o,
    output logic             wrap_o
);
    region_e          state, state_nx;
    logic [LEN_W-1:0] cnt, cnt_nx;
    logic [LEN_W-1:0] cur_len;
    logic             last;

    always_comb begin
        unique case (state)
            RG_SYNC:   cur_len = len_sync;
            RG_BACK:   cur_len = len_back;
            RG_ACTIVE: cur_len = len_active;
            RG_FRONT:  cur_len = len_front;
            default:   cur_len = len_sync;
        endcase
    end

    assign last = (cur_len == '0) || (cnt >= cur_len - LEN_W'(1));

    // Next-state and wrap decode
    always_comb begin
        state_nx = state;
        cnt_nx   = cnt;
        wrap_o   = 1'b0;
        if (step) begin
            if (last) begin
                cnt_nx = '0;
                unique case (state)
                    RG_SYNC:   state_nx = (len_back == '0) ? RG_ACTIVE : RG_BACK;
                    RG_BACK:   state_nx = RG_ACTIVE;
                    RG_ACTIVE: begin
                        if (len_front == '0) begin
                            state_nx = RG_SYNC;
                            wrap_o   = 1'b1;
                        end else begin
                            state_nx = RG_FRONT;
                        end
                    end
                    RG_FRONT: begin
                        state_nx = RG_SYNC;
                        wrap_o   = 1'b1;
                    end
                    default:   state_nx = RG_SYNC;
                endcase
            end else begin
                cnt_nx = cnt + LEN_W'(1);
            end
        end
    end

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state <= RG_SYNC;
            cnt   <= '0;
        end else if (!en) begin
            state <= RG_SYNC;
            cnt   <= '0;
        end else begin
            state <= state_nx;
            cnt   <= cnt_nx;
        end
    end

    assign region_o = state;

    // R3: without a step the position does not move
    a_r3_hold_without_step: assert property (@(posedge clk) disable iff (!rst_n)
        (en && $past(en) && !$past(step)) |-> ($stable(state) && $stable(cnt)));

    // R4: every newly entered region starts counting from zero
    a_r4_new_region_from_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (en && $past(en) && (state != $past(state))) |-> (cnt == '0));

endmodule

// File: rtl/lcdt_vmon.sv
module lcdt_vmon
    import lcdt_pkg::*;
(
    input  logic    clk,
    input  logic    rst_n,
    input  logic    en,
    input  region_e region_i,
    output logic    chg_o,
    output logic    frame_o
);
    region_e prev;

    // Idle value FRONT makes the first enabled cycle count as a new frame.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            prev <= RG_FRONT;
        end else if (!en) begin
            prev <= RG_FRONT;
        end else begin
            prev <= region_i;
        end
    end

    assign chg_o   = en & (region_i != prev);
    assign frame_o = chg_o & (region_i == RG_SYNC);

    // R8: a region change strobe lasts a single cycle
    a_r8_single_strobe: assert property (@(posedge clk) disable iff (!rst_n)
        chg_o |=> !chg_o);

endmodule

// File: rtl/lcd_timing_gen.sv
module lcd_timing_gen
    import lcdt_pkg::*;
#(
    parameter int PPL_W   = 6,
    parameter int HFLD_W  = 8,
    parameter int VSW_W   = 6,
    parameter int VPRCH_W = 8,
    parameter int LPP_W   = 10,
    parameter int PCD_W   = 10
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               en,
    input  logic [PPL_W-1:0]   ppl,
    input  logic [HFLD_W-1:0]  hsw,
    input  logic [HFLD_W-1:0]  hbp,
    input  logic [HFLD_W-1:0]  hfp,
    input  logic [VSW_W-1:0]   vsw,
    input  logic [VPRCH_W-1:0] vbp,
    input  logic [VPRCH_W-1:0] vfp,
    input  logic [LPP_W-1:0]   lpp,
    input  logic [PCD_W-1:0]   pcd,
    input  logic               div_bypass,
    input  logic               inv_hsync,
    input  logic               inv_vsync,
    input  logic               inv_de,
    input  logic               inv_pclk,
    output logic               pclk_en,
    output logic               pclk_out,
    output logic               hsync,
    output logic               vsync,
    output logic               de,
    output logic [1:0]         vregion,
    output logic               vregion_chg,
    output logic               frame_start
);
    localparam int W_PIX = PPL_W + 5;
    localparam int W_HF  = HFLD_W + 1;
    localparam int W_LN  = LPP_W + 1;
    localparam int W_VP  = VPRCH_W + 1;
    localparam int W_AB  = (W_PIX > W_HF) ? W_PIX : W_HF;
    localparam int W_CD  = (W_LN > W_VP) ? W_LN : W_VP;
    localparam int LEN_W = (W_AB > W_CD) ? W_AB : W_CD;

    logic             pclk_lvl;
    logic             h_wrap, v_wrap;
    region_e          h_reg, v_reg;
    logic [LEN_W-1:0] h_sync_len, h_back_len, h_act_len, h_front_len;
    logic [LEN_W-1:0] v_sync_len, v_back_len, v_act_len, v_front_len;
    logic             de_act;

    // Field decode into lengths
    assign h_sync_len  = LEN_W'(hsw) + LEN_W'(1);
    assign h_back_len  = LEN_W'(hbp) + LEN_W'(1);
    assign h_act_len   = (LEN_W'(ppl) + LEN_W'(1)) << 4;
    assign h_front_len = LEN_W'(hfp) + LEN_W'(1);
    assign v_sync_len  = LEN_W'(vsw) + LEN_W'(1);
    assign v_back_len  = LEN_W'(vbp);
    assign v_act_len   = LEN_W'(lpp) + LEN_W'(1);
    assign v_front_len = LEN_W'(vfp);

    lcdt_clkdiv #(.PCD_W(PCD_W)) u_div (
        .clk      (clk),
        .rst_n    (rst_n),
        .en       (en),
        .bypass   (div_bypass),
        .pcd      (pcd),
        .pclk_en  (pclk_en),
        .pclk_lvl (pclk_lvl)
    );

    lcdt_axis #(.LEN_W(LEN_W)) u_hax (
        .clk        (clk),
        .rst_n      (rst_n),
        .en         (en),
        .step       (pclk_en),
        .len_sync   (h_sync_len),
        .len_back   (h_back_len),
        .len_active (h_act_len),
        .len_front  (h_front_len),
        .region_o   (h_reg),
        .wrap_o     (h_wrap)
    );

    lcdt_axis #(.LEN_W(LEN_W)) u_vax (
        .clk        (clk),
        .rst_n      (rst_n),
        .en         (en),
        .step       (pclk_en & h_wrap),
        .len_sync   (v_sync_len),
        .len_back   (v_back_len),
        .len_active (v_act_len),
        .len_front  (v_front_len),
        .region_o   (v_reg),
        .wrap_o     (v_wrap)
    );

    lcdt_vmon u_vmon (
        .clk      (clk),
        .rst_n    (rst_n),
        .en       (en),
        .region_i (v_reg),
        .chg_o    (vregion_chg),
        .frame_o  (frame_start)
    );

    // Output decode and polarity
    always_comb begin
        de_act   = en && (h_reg == RG_ACTIVE) && (v_reg == RG_ACTIVE);
        hsync    = (en && (h_reg == RG_SYNC)) ^ inv_hsync;
        vsync    = (en && (v_reg == RG_SYNC)) ^ inv_vsync;
        de       = de_act ^ inv_de;
        pclk_out = pclk_lvl ^ inv_pclk;
        vregion  = en ? v_reg : RG_SYNC;
    end

    // R5: data enable only inside the active lines
    a_r5_de_in_active_lines: assert property (@(posedge clk) disable iff (!rst_n)
        de_act |-> (vregion == RG_ACTIVE));

    // R10: enabling restarts at a frame start in the sync region
    a_r10_restart_at_frame: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(en) |-> (frame_start && vregion == RG_SYNC));

    // R4: the vertical wrap only happens on a horizontal wrap
    a_r4_vwrap_on_line_end: assert property (@(posedge clk) disable iff (!rst_n)
        v_wrap |-> (h_wrap && pclk_en));

endmodule

// File: tb/lcd_timing_gen_test.sv
module lcd_timing_gen_test;

    typedef struct packed {
        logic [5:0] ppl;
        logic [7:0] hsw;
        logic [7:0] hbp;
        logic [7:0] hfp;
        logic [5:0] vsw;
        logic [7:0] vbp;
        logic [7:0] vfp;
        logic [9:0] lpp;
        logic [9:0] pcd;
        logic       byp;
        logic       ihs;
        logic       ivs;
        logic       ide;
        logic       ipc;
    } cfg_t;

    localparam int NROW = 6;
    localparam cfg_t CFG [NROW] = '{
        '{6'd0,  8'd1,   8'd0,   8'd2,   6'd0, 8'd1,   8'd1,   10'd2, 10'd0, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0},
        '{6'd0,  8'd1,   8'd0,   8'd2,   6'd0, 8'd0,   8'd0,   10'd2, 10'd0, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0},
        '{6'd1,  8'd0,   8'd3,   8'd0,   6'd2, 8'd2,   8'd0,   10'd0, 10'd3, 1'b0, 1'b0, 1'b1, 1'b1, 1'b1},
        '{6'd2,  8'd7,   8'd5,   8'd4,   6'd1, 8'd0,   8'd3,   10'd4, 10'd0, 1'b1, 1'b1, 1'b1, 1'b1, 1'b1},
        '{6'd63, 8'd255, 8'd255, 8'd255, 6'd0, 8'd0,   8'd0,   10'd0, 10'd0, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0},
        '{6'd0,  8'd0,   8'd0,   8'd0,   6'd0, 8'd255, 8'd255, 10'd0, 10'd1, 1'b0, 1'b0, 1'b0, 1'b0, 1'b1}
    };

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       en = 1'b0;
    logic [5:0] ppl = '0;
    logic [7:0] hsw = '0, hbp = '0, hfp = '0;
    logic [5:0] vsw = '0;
    logic [7:0] vbp = '0, vfp = '0;
    logic [9:0] lpp = '0;
    logic [9:0] pcd = '0;
    logic       div_bypass = 1'b0;
    logic       inv_hsync = 1'b0, inv_vsync = 1'b0, inv_de = 1'b0, inv_pclk = 1'b0;
    logic       pclk_en, pclk_out, hsync, vsync, de, vregion_chg, frame_start;
    logic [1:0] vregion;

    int n_chk = 0;
    int n_bad = 0;

    always #2 clk = ~clk;

    lcd_timing_gen uut (
        .clk(clk), .rst_n(rst_n), .en(en),
        .ppl(ppl), .hsw(hsw), .hbp(hbp), .hfp(hfp),
        .vsw(vsw), .vbp(vbp), .vfp(vfp), .lpp(lpp), .pcd(pcd),
        .div_bypass(div_bypass), .inv_hsync(inv_hsync), .inv_vsync(inv_vsync),
        .inv_de(inv_de), .inv_pclk(inv_pclk),
        .pclk_en(pclk_en), .pclk_out(pclk_out), .hsync(hsync), .vsync(vsync),
        .de(de), .vregion(vregion), .vregion_chg(vregion_chg), .frame_start(frame_start)
    );

    task automatic chk(input bit ok, input string req, input string what,
                       input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    function automatic int region_at(int pos, int a, int b, int c);
        if (pos < a) return 0;
        if (pos < a + b) return 1;
        if (pos < a + b + c) return 2;
        return 3;
    endfunction

    task automatic load_cfg(input cfg_t c);
        ppl = c.ppl; hsw = c.hsw; hbp = c.hbp; hfp = c.hfp;
        vsw = c.vsw; vbp = c.vbp; vfp = c.vfp; lpp = c.lpp; pcd = c.pcd;
        div_bypass = c.byp; inv_hsync = c.ihs; inv_vsync = c.ivs;
        inv_de = c.ide; inv_pclk = c.ipc;
    endtask

    // Enable at a negedge and compare every cycle against the position formula.
    task automatic run_cfg(input cfg_t c, input string tag, input int extra_lines);
        int n, hs, hb, ha, hf, vs, vb, va, vf, ll, ff, ncyc, prev_vr;
        int err[8], fk[8], fa[8], fe[8], act[8], exp[8];
        string nm[8];
        string rq[8];
        nm = '{"pclk_en", "pclk_out", "hsync", "vsync", "de", "vregion", "vregion_chg", "frame_start"};
        rq = '{"R1", "R2", "R3/R6", "R4/R6", "R5", "R7", "R8", "R9"};
        n  = c.byp ? 1 : int'(c.pcd) + 2;
        hs = int'(c.hsw) + 1; hb = int'(c.hbp) + 1;
        ha = 16 * (int'(c.ppl) + 1); hf = int'(c.hfp) + 1;
        vs = int'(c.vsw) + 1; vb = int'(c.vbp);
        va = int'(c.lpp) + 1; vf = int'(c.vfp);
        ll = hs + hb + ha + hf;
        ff = vs + vb + va + vf;
        ncyc = (ff + extra_lines) * ll * n + 5;
        for (int i = 0; i < 8; i++) begin err[i] = 0; fk[i] = 0; fa[i] = 0; fe[i] = 0; end
        prev_vr = 3;
        @(negedge clk);
        load_cfg(c);
        en = 1'b1;
        for (int k = 0; k < ncyc; k++) begin
            int p, hr, vr;
            #1;
            p  = k / n;
            hr = region_at(p % ll, hs, hb, ha);
            vr = region_at((p / ll) % ff, vs, vb, va);
            exp[0] = c.byp ? 1 : int'((k % n) == n - 1);
            exp[1] = c.byp ? int'(c.ipc) : (int'((k % n) < n / 2) ^ int'(c.ipc));
            exp[2] = int'(hr == 0) ^ int'(c.ihs);
            exp[3] = int'(vr == 0) ^ int'(c.ivs);
            exp[4] = int'(hr == 2 && vr == 2) ^ int'(c.ide);
            exp[5] = vr;
            exp[6] = int'(vr != prev_vr);
            exp[7] = int'(vr != prev_vr && vr == 0);
            act[0] = int'(pclk_en); act[1] = int'(pclk_out); act[2] = int'(hsync);
            act[3] = int'(vsync); act[4] = int'(de); act[5] = int'(vregion);
            act[6] = int'(vregion_chg); act[7] = int'(frame_start);
            for (int i = 0; i < 8; i++) begin
                if (act[i] != exp[i]) begin
                    if (err[i] == 0) begin fk[i] = k; fa[i] = act[i]; fe[i] = exp[i]; end
                    err[i]++;
                end
            end
            prev_vr = vr;
            @(negedge clk);
        end
        for (int i = 0; i < 8; i++)
            chk(err[i] == 0, rq[i], $sformatf("%s %s first bad cycle %0d", tag, nm[i], fk[i]),
                fa[i], fe[i]);
    endtask

    task automatic chk_idle(input string tag);
        chk(hsync == inv_hsync, "R10", {tag, " hsync"}, int'(hsync), int'(inv_hsync));
        chk(vsync == inv_vsync, "R10", {tag, " vsync"}, int'(vsync), int'(inv_vsync));
        chk(de == inv_de, "R10", {tag, " de"}, int'(de), int'(inv_de));
        chk(pclk_out == inv_pclk, "R10", {tag, " pclk_out"}, int'(pclk_out), int'(inv_pclk));
        chk(!pclk_en && !vregion_chg && !frame_start, "R10", {tag, " strobes"},
            int'({pclk_en, vregion_chg, frame_start}), 0);
        chk(vregion == 2'b00, "R10", {tag, " vregion"}, int'(vregion), 0);
    endtask

    task automatic finish_run();
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    endtask

    initial begin
        #800000;
        n_chk++;
        n_bad++;
        $display("FAIL watchdog expired");
        finish_run();
    end

    initial begin
        // Reset state with the block disabled
        repeat (3) @(negedge clk);
        #1;
        chk_idle("reset");
        rst_n = 1'b1;
        @(negedge clk);
        #1;
        chk_idle("after reset");

        // Table of configurations, each over one frame plus a line
        for (int r = 0; r < NROW; r++) begin
            run_cfg(CFG[r], (r == 4 || r == 5) ? $sformatf("R11 row%0d", r) : $sformatf("row%0d", r), 1);
            en = 1'b0;
            @(negedge clk);
        end

        // R10: disable in mid-frame, stay idle, then restart from a frame start
        run_cfg(CFG[3], "R10 pre-disable", 0);
        en = 1'b0;
        #1;
        chk_idle("R10 mid-frame");
        repeat (4) @(negedge clk);
        #1;
        chk_idle("R10 held");
        run_cfg(CFG[3], "R10 restart", 1);
        en = 1'b0;
        @(negedge clk);

        // R10: divided mode disabled in the middle of a pixel period
        load_cfg(CFG[2]);
        en = 1'b1;
        repeat (7) @(negedge clk);
        en = 1'b0;
        #1;
        chk_idle("R10 divided");
        run_cfg(CFG[2], "R10 divided restart", 0);

        finish_run();
    end

endmodule